// File: doc/BRIEF.md
# Plesiochronous Tributary Bit-Stuffing Multiplexer

This block carries one tributary bit stream, clocked by its own free-running write clock, into a fixed multiplex frame. The frame is read on a common clock that is a little faster than any tributary. Incoming bits go into a small elastic store. On the read side, an external frame counter presents one slot type per read cycle, and the block turns each slot into an output bit with a marker that says what kind of bit it is.

Each frame has one justification slot for this tributary. Because the read side is faster, the store slowly drains. Once per frame, at the first control slot, the block compares the read-side fill level with a low threshold. If the fill is at or below the threshold, the justification slot is stuffed. Otherwise it carries the next stored bit. The decision is repeated in every control slot of the frame, so a receiver can recover it by majority vote even if one control bit is corrupted.

Write and read pointers are binary counters with one wrap bit. The write pointer crosses into the read domain as a Gray code through a flop synchronizer.

Top module: `pdh_justify_mux`

## Requirements
- R1: Every tributary bit accepted (trib_valid high on a write clock edge) leaves exactly once, in arrival order, either in a data slot (out_kind 1) or in a data-carrying justification slot (out_kind 3). No bit is lost or repeated.
- R2: The output is registered. One read cycle after a slot is presented, out_kind reflects that slot.
  - slot_type codes: 0 fixed, 1 data, 2 control, 3 justification.
  - out_kind codes: 0 fixed, 1 data, 2 control, 3 justification carrying data, 4 justification stuffed.
  - A control slot gives out_kind 2. A justification slot gives out_kind 3 or 4.
- R3: While rd_rst_n is low, out_kind is 0 and out_bit is 0.
- R4: The first control slot after the previous justification slot (or after reset) takes the decision. The decision is 1 (stuff) when the read-side fill level is at or below LOW_FILL (default 2), and 0 otherwise.
- R5: Every control slot of a frame outputs the same bit, equal to the decision held for that frame.
- R6: In a justification slot with decision 1, out_kind is 4, out_bit is 0 and the store is not read. With decision 0, out_kind is 3 and out_bit is the next stored bit.
- R7: A fixed slot outputs bit 0 and does not read the store.
- R8: A justification slot that arrives before any control slot since reset is stuffed (out_kind 4).
- R9: The read-side fill level never exceeds DEPTH. No data slot finds the store empty while the tributary delivers between 18 and 19 bits per 24-slot frame.
- R10: With the write rate inside that window, each run produces both stuffed and data-carrying justification slots.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Tributary write clock |
| wr_rst_n | input | 1 | Active-low reset, write domain |
| trib_bit | input | 1 | Tributary data bit |
| trib_valid | input | 1 | Writes trib_bit into the store on this edge |
| rd_clk | input | 1 | Common multiplex read clock |
| rd_rst_n | input | 1 | Active-low reset, read domain |
| slot_type | input | 2 | Kind of the current frame slot from the frame counter |
| out_bit | output | 1 | Serial multiplex output bit |
| out_kind | output | 3 | Marker for the type of out_bit |

## Verification
The assertions assume two things about the inputs:
- The frame counter presents exactly three control slots before each justification slot.
- The tributary rate keeps the store from emptying during a data slot.

The underflow-freedom property only holds under the second assumption. The stimulus stays inside both assumptions. It uses a fixed 24-slot frame with three control slots and one justification slot. It sets the write rate near 18.9 bits per frame, swept by -50, 0 and +50 ppm at two start phases. It pre-fills the store for a few read cycles before the first frame.

// File: rtl/pdh_jmux_pkg.sv
package pdh_jmux_pkg;

    // Slot kinds presented by the external frame counter
    typedef enum logic [1:0] {
        SLOT_FIXED = 2'd0,
        SLOT_DATA  = 2'd1,
        SLOT_CTRL  = 2'd2,
        SLOT_JUST  = 2'd3
    } slot_e;

    // Marker attached to each output bit
    typedef enum logic [2:0] {
        OUT_FIXED  = 3'd0,
        OUT_DATA   = 3'd1,
        OUT_CTRL   = 3'd2,
        OUT_JDATA  = 3'd3,
        OUT_JSTUFF = 3'd4
    } kind_e;

endpackage

// File: rtl/pdh_jmux_wr.sv
module pdh_jmux_wr #(
    parameter  int DEPTH = 8,
    localparam int AW    = $clog2(DEPTH),
    localparam int PW    = AW + 1
) (
    input  logic             wr_clk,
    input  logic             wr_rst_n,
    input  logic             bit_i,
    input  logic             valid_i,
    output logic [DEPTH-1:0] store_o,
    output logic [PW-1:0]    wr_gray_o
);

    typedef struct packed {
        logic [PW-1:0]    bin;
        logic [PW-1:0]    gray;
        logic [DEPTH-1:0] mem;
    } wr_state_t;

    wr_state_t q, d;

    always_comb begin
        d = q;
        if (valid_i) begin
            d.mem[q.bin[AW-1:0]] = bit_i;
            d.bin                = q.bin + 1'b1;
            d.gray               = d.bin ^ (d.bin >> 1);
        end
    end

    always_ff @(posedge wr_clk or negedge wr_rst_n) begin
        if (!wr_rst_n) q <= '0;
        else           q <= d;
    end

    assign store_o   = q.mem;
    assign wr_gray_o = q.gray;

endmodule

// File: rtl/pdh_jmux_sync.sv
module pdh_jmux_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [STAGES-1:0][W-1:0] chain_q, chain_d;

    always_comb begin
        chain_d[0] = d_i;
        for (int s = 1; s < STAGES; s++) chain_d[s] = chain_q[s-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/pdh_jmux_rd.sv
module pdh_jmux_rd
    import pdh_jmux_pkg::*;
#(
    parameter  int DEPTH    = 8,
    parameter  int LOW_FILL = 2,
    localparam int AW       = $clog2(DEPTH),
    localparam int PW       = AW + 1
) (
    input  logic             rd_clk,
    input  logic             rd_rst_n,
    input  logic [1:0]       slot_i,
    input  logic [DEPTH-1:0] store_i,
    input  logic [PW-1:0]    wr_gray_i,
    output logic             out_bit_o,
    output logic [2:0]       out_kind_o,
    output logic [PW-1:0]    fill_o
);

    typedef struct packed {
        logic [PW-1:0] rd_bin;
        logic          stuff;   // decision held for the current frame
        logic [1:0]    c_cnt;   // control slots since last justification slot
        logic          obit;
        kind_e         okind;
    } rd_state_t;

    rd_state_t q, d;

    logic [PW-1:0] wr_bin;
    logic [PW-1:0] fill;
    logic          empty;
    logic          head;
    logic          want_stuff;

    function automatic logic [PW-1:0] gray_to_bin(input logic [PW-1:0] g);
        logic [PW-1:0] b;
        b[PW-1] = g[PW-1];
        for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
        return b;
    endfunction

    always_comb begin
        wr_bin     = gray_to_bin(wr_gray_i);
        fill       = wr_bin - q.rd_bin;
        empty      = (fill == '0);
        head       = store_i[q.rd_bin[AW-1:0]];
        want_stuff = (fill <= PW'(LOW_FILL));

        d      = q;
        d.obit = 1'b0;
        case (slot_e'(slot_i))
            SLOT_FIXED: d.okind = OUT_FIXED;
            SLOT_DATA: begin
                d.okind = OUT_DATA;
                if (!empty) begin
                    d.obit   = head;
                    d.rd_bin = q.rd_bin + 1'b1;
                end
            end
            SLOT_CTRL: begin
                d.okind = OUT_CTRL;
                if (q.c_cnt == 2'd0) begin
                    d.stuff = want_stuff;
                    d.obit  = want_stuff;
                end else begin
                    d.obit  = q.stuff;
                end
                if (q.c_cnt != 2'd3) d.c_cnt = q.c_cnt + 2'd1;
            end
            SLOT_JUST: begin
                d.c_cnt = 2'd0;
                if (q.stuff) begin
                    d.okind = OUT_JSTUFF;
                end else begin
                    d.okind = OUT_JDATA;
                    if (!empty) begin
                        d.obit   = head;
                        d.rd_bin = q.rd_bin + 1'b1;
                    end
                end
            end
            default: d.okind = OUT_FIXED;
        endcase
    end

    always_ff @(posedge rd_clk or negedge rd_rst_n) begin
        if (!rd_rst_n) begin
            q        <= '0;
            q.stuff  <= 1'b1;
            q.okind  <= OUT_FIXED;
        end else begin
            q <= d;
        end
    end

    assign out_bit_o  = q.obit;
    assign out_kind_o = q.okind;
    assign fill_o     = fill;

endmodule

// File: rtl/pdh_justify_mux.sv
module pdh_justify_mux #(
    parameter  int DEPTH       = 8,
    parameter  int LOW_FILL    = 2,
    parameter  int SYNC_STAGES = 2,
    localparam int AW          = $clog2(DEPTH),
    localparam int PW          = AW + 1
) (
    input  logic       wr_clk,
    input  logic       wr_rst_n,
    input  logic       trib_bit,
    input  logic       trib_valid,
    input  logic       rd_clk,
    input  logic       rd_rst_n,
    input  logic [1:0] slot_type,
    output logic       out_bit,
    output logic [2:0] out_kind
);

    logic [DEPTH-1:0] store;
    logic [PW-1:0]    wr_gray;
    logic [PW-1:0]    wr_gray_rd;
    logic [PW-1:0]    rd_fill;

    pdh_jmux_wr #(.DEPTH(DEPTH)) wr_i (
        .wr_clk    (wr_clk),
        .wr_rst_n  (wr_rst_n),
        .bit_i     (trib_bit),
        .valid_i   (trib_valid),
        .store_o   (store),
        .wr_gray_o (wr_gray)
    );

    pdh_jmux_sync #(.W(PW), .STAGES(SYNC_STAGES)) sync_i (
        .clk   (rd_clk),
        .rst_n (rd_rst_n),
        .d_i   (wr_gray),
        .q_o   (wr_gray_rd)
    );

    pdh_jmux_rd #(.DEPTH(DEPTH), .LOW_FILL(LOW_FILL)) rd_i (
        .rd_clk     (rd_clk),
        .rd_rst_n   (rd_rst_n),
        .slot_i     (slot_type),
        .store_i    (store),
        .wr_gray_i  (wr_gray_rd),
        .out_bit_o  (out_bit),
        .out_kind_o (out_kind),
        .fill_o     (rd_fill)
    );

endmodule

// File: rtl/pdh_justify_mux_chk.sv
module pdh_justify_mux_chk
    import pdh_jmux_pkg::*;
#(
    parameter  int DEPTH    = 8,
    parameter  int LOW_FILL = 2,
    localparam int PW       = $clog2(DEPTH) + 1
) (
    input logic          rd_clk,
    input logic          rd_rst_n,
    input logic [1:0]    slot_type,
    input logic          out_bit,
    input logic [2:0]    out_kind,
    input logic [PW-1:0] rd_fill
);

    logic       last_c_q;
    logic [1:0] oc_q;   // control outputs seen since last justification output
    logic [1:0] sc_q;   // control slots presented since last justification slot

    always_ff @(posedge rd_clk or negedge rd_rst_n) begin
        if (!rd_rst_n) begin
            last_c_q <= 1'b0;
            oc_q     <= 2'd0;
            sc_q     <= 2'd0;
        end else begin
            if (out_kind == OUT_CTRL) begin
                if (oc_q == 2'd0) last_c_q <= out_bit;
                if (oc_q != 2'd3) oc_q <= oc_q + 2'd1;
            end else if (out_kind == OUT_JDATA || out_kind == OUT_JSTUFF) begin
                oc_q <= 2'd0;
            end
            if (slot_type == SLOT_CTRL) begin
                if (sc_q != 2'd3) sc_q <= sc_q + 2'd1;
            end else if (slot_type == SLOT_JUST) begin
                sc_q <= 2'd0;
            end
        end
    end

    p_kind_fixed_r2: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        slot_type == SLOT_FIXED |=> out_kind == OUT_FIXED);
    p_kind_data_r2: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        slot_type == SLOT_DATA |=> out_kind == OUT_DATA);
    p_kind_ctrl_r2: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        slot_type == SLOT_CTRL |=> out_kind == OUT_CTRL);
    p_kind_just_r2: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        slot_type == SLOT_JUST |=> (out_kind == OUT_JDATA || out_kind == OUT_JSTUFF));

    p_decision_r4: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        (slot_type == SLOT_CTRL && sc_q == 2'd0) |=> out_bit == $past(rd_fill <= PW'(LOW_FILL)));

    p_c_repeat_r5: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        (out_kind == OUT_CTRL && oc_q != 2'd0) |-> out_bit == last_c_q);

    p_stuff_follows_c_r6: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        out_kind == OUT_JSTUFF |-> (oc_q == 2'd0 || last_c_q));
    p_data_follows_c_r6: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        out_kind == OUT_JDATA |-> (oc_q != 2'd0 && !last_c_q));
    p_stuff_zero_r6: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        out_kind == OUT_JSTUFF |-> !out_bit);

    p_fixed_zero_r7: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        out_kind == OUT_FIXED |-> !out_bit);

    p_no_overflow_r9: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        rd_fill <= PW'(DEPTH));
    p_no_underflow_r9: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        slot_type == SLOT_DATA |-> rd_fill != '0);

endmodule

bind pdh_justify_mux pdh_justify_mux_chk #(.DEPTH(DEPTH), .LOW_FILL(LOW_FILL)) chk_i (
    .rd_clk    (rd_clk),
    .rd_rst_n  (rd_rst_n),
    .slot_type (slot_type),
    .out_bit   (out_bit),
    .out_kind  (out_kind),
    .rd_fill   (rd_fill)
);

// File: tb/pdh_justify_mux_tb_top.sv
module pdh_justify_mux_tb_top;
    import pdh_jmux_pkg::*;

    localparam int     CLK_PERIOD  = 10000;          // read clock, ps
    localparam int     WR_NOM_PS   = 12698;          // about 18.9 writes per frame
    localparam int     FRAME_LEN   = 24;
    localparam int     FRAMES      = 600;
    localparam int     DEPTH       = 8;
    localparam int     LOW_FILL    = 2;
    localparam longint WATCHDOG_PS = 64'd200000 * CLK_PERIOD;

    logic       wr_clk     = 1'b0;
    logic       rd_clk     = 1'b0;
    logic       wr_rst_n   = 1'b0;
    logic       rd_rst_n   = 1'b0;
    logic       trib_bit   = 1'b0;
    logic       trib_valid = 1'b0;
    logic [1:0] slot_type  = SLOT_FIXED;
    logic       out_bit;
    logic [2:0] out_kind;

    int   n_checks = 0;
    int   n_fail   = 0;
    int   wr_idx   = 0;
    int   rx_idx   = 0;
    int   c_n      = 0;
    int   n_stuff  = 0;
    int   n_sdata  = 0;
    logic c_first  = 1'b0;
    logic [1:0] prev_slot = SLOT_FIXED;
    bit   wr_go    = 1'b0;
    real  wr_half  = WR_NOM_PS / 2.0;

    pdh_justify_mux #(.DEPTH(DEPTH), .LOW_FILL(LOW_FILL)) dut_i (
        .wr_clk     (wr_clk),
        .wr_rst_n   (wr_rst_n),
        .trib_bit   (trib_bit),
        .trib_valid (trib_valid),
        .rd_clk     (rd_clk),
        .rd_rst_n   (rd_rst_n),
        .slot_type  (slot_type),
        .out_bit    (out_bit),
        .out_kind   (out_kind)
    );

    initial forever #(CLK_PERIOD / 2) rd_clk = ~rd_clk;

    // Write clock with fractional period kept exact on average
    initial begin
        real t_ideal;
        real t_int;
        int  dly;
        t_ideal = 0.0;
        t_int   = 0.0;
        forever begin
            dly     = $rtoi(t_ideal + wr_half - t_int + 0.5);
            t_ideal = t_ideal + wr_half;
            t_int   = t_int + dly;
            #(dly) wr_clk = ~wr_clk;
        end
    end

    function automatic logic pat(input int k);
        logic [31:0] x;
        x = 32'(k) * 32'h9E3779B1;
        return x[19] ^ x[7] ^ x[2];
    endfunction

    function automatic logic [1:0] slot_at(input int p);
        if (p < 2)                          return SLOT_FIXED;
        if (p == 4 || p == 10 || p == 16)   return SLOT_CTRL;
        if (p == 20)                        return SLOT_JUST;
        return SLOT_DATA;
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (rx bit %0d)", tag, act, exp, rx_idx);
        end
    endtask

    // Tributary driver: one bit per write clock while enabled
    initial forever begin
        @(negedge wr_clk);
        if (wr_go) begin
            trib_bit   = pat(wr_idx);
            trib_valid = 1'b1;
            wr_idx++;
        end else begin
            trib_valid = 1'b0;
        end
    end

    // Demultiplex one output sample against the expected stream
    task automatic take_output();
        logic [2:0] k;
        logic       b;
        int         slack;
        k = out_kind;
        b = out_bit;
        case (prev_slot)
            SLOT_FIXED: check(k == OUT_FIXED, "R2", int'(k), int'(OUT_FIXED));
            SLOT_DATA:  check(k == OUT_DATA,  "R2", int'(k), int'(OUT_DATA));
            SLOT_CTRL:  check(k == OUT_CTRL,  "R2", int'(k), int'(OUT_CTRL));
            default:    check(k == OUT_JDATA || k == OUT_JSTUFF, "R2", int'(k), int'(OUT_JDATA));
        endcase
        if (k == OUT_FIXED) begin
            check(b == 1'b0, "R7", int'(b), 0);
        end else if (k == OUT_DATA) begin
            check(b == pat(rx_idx), "R1", int'(b), int'(pat(rx_idx)));
            rx_idx++;
        end else if (k == OUT_CTRL) begin
            if (c_n == 0) begin
                c_first = b;
                slack   = wr_idx - rx_idx;
                if (b) check(slack <= LOW_FILL + 6, "R4", slack, LOW_FILL + 6);
                else   check(slack >= LOW_FILL + 1, "R4", slack, LOW_FILL + 1);
            end else begin
                check(b == c_first, "R5", int'(b), int'(c_first));
            end
            c_n++;
        end else if (k == OUT_JDATA || k == OUT_JSTUFF) begin
            if (c_n == 0) begin
                check(k == OUT_JSTUFF, "R8", int'(k), int'(OUT_JSTUFF));
            end else begin
                // receiver vote over the three control bits; all agree here
                check(k == (c_first ? OUT_JSTUFF : OUT_JDATA), "R6", int'(k),
                      int'(c_first ? OUT_JSTUFF : OUT_JDATA));
            end
            if (k == OUT_JSTUFF) begin
                check(b == 1'b0, "R6", int'(b), 0);
                n_stuff++;
            end else begin
                check(b == pat(rx_idx), "R1", int'(b), int'(pat(rx_idx)));
                rx_idx++;
                n_sdata++;
            end
            c_n = 0;
        end else begin
            check(1'b0, "R2", int'(k), int'(OUT_FIXED));
        end
    endtask

    task automatic step(input logic [1:0] s);
        @(negedge rd_clk);
        take_output();
        slot_type = s;
        prev_slot = s;
    endtask

    task automatic run(input real ppm, input int skew);
        wr_go     = 1'b0;
        wr_rst_n  = 1'b0;
        rd_rst_n  = 1'b0;
        slot_type = SLOT_FIXED;
        prev_slot = SLOT_FIXED;
        wr_half   = (WR_NOM_PS / (1.0 + ppm * 1.0e-6)) / 2.0;
        repeat (4) @(negedge rd_clk);
        check(out_kind == OUT_FIXED, "R3", int'(out_kind), int'(OUT_FIXED));
        check(out_bit == 1'b0, "R3", int'(out_bit), 0);
        if (skew > 0) #(skew);
        wr_idx  = 0;
        rx_idx  = 0;
        c_n     = 0;
        n_stuff = 0;
        n_sdata = 0;
        @(negedge wr_clk);
        wr_rst_n = 1'b1;
        wr_go    = 1'b1;
        @(negedge rd_clk);
        rd_rst_n = 1'b1;
        // pre-fill, then a justification slot before any control slot (R8)
        repeat (5) step(SLOT_FIXED);
        step(SLOT_JUST);
        for (int f = 0; f < FRAMES; f++) begin
            for (int p = 0; p < FRAME_LEN; p++) step(slot_at(p));
        end
        step(SLOT_FIXED);
        wr_go = 1'b0;
        check(n_stuff > 0, "R10", n_stuff, 1);
        check(n_sdata > 0, "R10", n_sdata, 1);
        check(wr_idx - rx_idx >= 0 && wr_idx - rx_idx <= DEPTH + 3, "R1",
              wr_idx - rx_idx, DEPTH);
    endtask

    initial begin
        for (int i = 0; i < 3; i++) begin
            for (int j = 0; j < 2; j++) begin
                run(-50.0 + 50.0 * i, j * 4321);
            end
        end
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(WATCHDOG_PS);
        n_checks++;
        n_fail++;
        $display("FAIL R1 watchdog: actual %0d expected %0d", rx_idx, wr_idx);
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule